// File: doc/BRIEF.md
# Signed Multiply-Accumulate Unit with Draining Readout

This block keeps a 64-bit signed running sum of products of two 32-bit signed operands. The sum is held as two 32-bit halves, an upper half (bits 63:32) and a lower half (bits 31:0). Both halves are always visible at the outputs, so a processor can read them as special registers.

An operation is issued by raising a valid strobe together with a two-bit operation code and the two operands. Three operations exist. The first adds the full signed product to the sum. The second subtracts the product from the sum. The third drains the sum: it returns a 32-bit window of the sum taken after an arithmetic shift right by 28 places, and clears the sum to zero in the same cycle. Every operation completes in one clock, so the next operation, including a drain, sees the previous result without any interlock.

A separate load port writes either half, or both, directly. It is meant for special-register writes. When an operation is issued in the same cycle as a load, the operation takes effect and the load is dropped.

Top module: `macc_unit`

## Requirements
- R1: While `rst` is high, both accumulator halves, `rd_value` and `rd_valid` are zero on the next clock edge.
- R2: With `op_valid` high and `op_code` = 2'b01 (add), the 64-bit sum `{acc_hi, acc_lo}` after the clock edge equals the previous sum plus the 64-bit signed product of `opnd_a` and `opnd_b`.
- R3: With `op_valid` high and `op_code` = 2'b10 (subtract), the sum after the edge equals the previous sum minus the signed product.
- R4: Add and subtract wrap modulo 2^64 and never saturate. For example, 0x7FFFFFFF_FFFFFFFF plus 1 gives 0x80000000_00000000.
- R5: With `op_valid` high and `op_code` = 2'b11 (drain), `rd_value` after the edge equals bits [59:28] of the previous sum, which is the low 32 bits of the sum arithmetically shifted right by 28. In the same edge both halves become zero.
- R6: `rd_valid` is high for exactly the one cycle after each drain and is low otherwise.
- R7: Operations issued in consecutive cycles each act on the result of the one before. A drain issued directly after an add returns a value that includes that add.
- R8: The sum and `rd_value` do not change in a cycle where `op_valid` is low and no load is requested, or where `op_valid` is high with `op_code` = 2'b00 (idle). An `op_code` presented while `op_valid` is low has no effect.
- R9: With `op_valid` low, `ld_hi_en` writes `ld_data` into bits 63:32 and `ld_lo_en` writes `ld_data` into bits 31:0. Each load leaves the other half unchanged, and both may be raised together.
- R10: With `op_valid` high, `ld_hi_en` and `ld_lo_en` are ignored, and the result is that of the operation alone.
- R11: `rd_value` keeps the value from the most recent drain until the next drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Issue strobe for an operation |
| op_code | input | 2 | 00 idle, 01 add, 10 subtract, 11 drain |
| opnd_a | input | 32 | First signed operand |
| opnd_b | input | 32 | Second signed operand |
| ld_hi_en | input | 1 | Write `ld_data` into the upper half |
| ld_lo_en | input | 1 | Write `ld_data` into the lower half |
| ld_data | input | 32 | Data for direct half writes |
| acc_hi | output | 32 | Accumulator bits 63:32 |
| acc_lo | output | 32 | Accumulator bits 31:0 |
| rd_value | output | 32 | Window from the most recent drain |
| rd_valid | output | 1 | One-cycle pulse after a drain |

## Verification
Add and subtract are swept over every ordered pair from a set of edge operands: zero, one, minus one, the largest positive and most negative values, a mid-range pattern and a power of two. This separates a signed product from an unsigned one, shows whether the upper product half is sign-extended, and catches add and subtract being swapped. Drains are issued at several points of that sweep, and also on a preloaded negative sum, so the bench can tell an arithmetic shift from a logical one and from a wrong window. Dedicated cases cover wrap-around at the positive limit, an issue code with a low strobe, the idle code, single and dual half loads, and a load that collides with an operation.

// File: rtl/macc_pkg.sv
`timescale 1ns/1ps
package macc_pkg;
  typedef enum logic [1:0] {
    MACC_IDLE  = 2'b00,
    MACC_ADD   = 2'b01,
    MACC_SUB   = 2'b10,
    MACC_DRAIN = 2'b11
  } macc_op_e;
endpackage

// File: rtl/macc_mult.sv
`timescale 1ns/1ps
// Full-width signed product of two OPW-bit operands.
module macc_mult #(
  parameter int OPW = 32,
  localparam int PW = 2 * OPW
) (
  input  logic [OPW-1:0] mul_a,
  input  logic [OPW-1:0] mul_b,
  output logic [PW-1:0]  mul_p
);
  logic signed [PW-1:0] a_ext;
  logic signed [PW-1:0] b_ext;
  logic signed [PW-1:0] p_s;

  assign a_ext = $signed({{OPW{mul_a[OPW-1]}}, mul_a});
  assign b_ext = $signed({{OPW{mul_b[OPW-1]}}, mul_b});

  always_comb begin
    p_s   = a_ext * b_ext;
    mul_p = p_s;
  end
endmodule

// File: rtl/macc_next.sv
`timescale 1ns/1ps
// Next-state selection for the accumulator: operation first, then half loads.
module macc_next
  import macc_pkg::*;
#(
  parameter int OPW = 32,
  localparam int ACCW  = 2 * OPW,
  localparam int HALVES = 2
) (
  input  logic [ACCW-1:0] cur_acc,
  input  logic [ACCW-1:0] product,
  input  logic            op_valid,
  input  logic [1:0]      op_code,
  input  logic            ld_hi_en,
  input  logic            ld_lo_en,
  input  logic [OPW-1:0]  ld_data,
  output logic [ACCW-1:0] nxt_acc,
  output logic            drain_go
);
  logic [ACCW-1:0]   loaded;
  logic [HALVES-1:0] half_we;

  assign half_we = {ld_hi_en, ld_lo_en};

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign loaded[h*OPW +: OPW] = half_we[h] ? ld_data : cur_acc[h*OPW +: OPW];
  end

  assign drain_go = op_valid && (op_code == MACC_DRAIN);

  always_comb begin
    nxt_acc = loaded;
    if (op_valid) begin
      case (op_code)
        MACC_ADD:   nxt_acc = cur_acc + product;
        MACC_SUB:   nxt_acc = cur_acc - product;
        MACC_DRAIN: nxt_acc = '0;
        default:    nxt_acc = cur_acc;
      endcase
    end
  end
endmodule

// File: rtl/macc_extract.sv
`timescale 1ns/1ps
// Arithmetic right shift of the accumulator, keeping the low OPW bits.
module macc_extract #(
  parameter int OPW   = 32,
  parameter int SHIFT = 28,
  localparam int ACCW = 2 * OPW
) (
  input  logic [ACCW-1:0] ext_acc,
  output logic [OPW-1:0]  ext_win
);
  logic signed [ACCW-1:0] shifted;

  always_comb begin
    shifted = $signed(ext_acc) >>> SHIFT;
    ext_win = shifted[OPW-1:0];
  end
endmodule

// File: rtl/macc_unit.sv
`timescale 1ns/1ps
module macc_unit #(
  parameter int OPW   = 32,
  parameter int SHIFT = 28
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           op_valid,
  input  logic [1:0]     op_code,
  input  logic [OPW-1:0] opnd_a,
  input  logic [OPW-1:0] opnd_b,
  input  logic           ld_hi_en,
  input  logic           ld_lo_en,
  input  logic [OPW-1:0] ld_data,
  output logic [OPW-1:0] acc_hi,
  output logic [OPW-1:0] acc_lo,
  output logic [OPW-1:0] rd_value,
  output logic           rd_valid
);
  localparam int ACCW = 2 * OPW;

  logic [ACCW-1:0] acc_q;
  logic [ACCW-1:0] prod;
  logic [ACCW-1:0] acc_d;
  logic [OPW-1:0]  win;
  logic            drain_go;

  macc_mult #(.OPW(OPW)) u_mult (
    .mul_a (opnd_a),
    .mul_b (opnd_b),
    .mul_p (prod)
  );

  macc_next #(.OPW(OPW)) u_next (
    .cur_acc  (acc_q),
    .product  (prod),
    .op_valid (op_valid),
    .op_code  (op_code),
    .ld_hi_en (ld_hi_en),
    .ld_lo_en (ld_lo_en),
    .ld_data  (ld_data),
    .nxt_acc  (acc_d),
    .drain_go (drain_go)
  );

  macc_extract #(.OPW(OPW), .SHIFT(SHIFT)) u_extract (
    .ext_acc (acc_q),
    .ext_win (win)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      rd_value <= '0;
      rd_valid <= 1'b0;
    end else begin
      acc_q    <= acc_d;
      rd_valid <= drain_go;
      if (drain_go) rd_value <= win;
    end
  end

  assign acc_hi = acc_q[ACCW-1:OPW];
  assign acc_lo = acc_q[OPW-1:0];
endmodule

// File: rtl/macc_unit_chk.sv
`timescale 1ns/1ps
module macc_unit_chk #(
  parameter int OPW   = 32,
  parameter int SHIFT = 28
) (
  input logic           clk,
  input logic           rst,
  input logic           op_valid,
  input logic [1:0]     op_code,
  input logic [OPW-1:0] opnd_a,
  input logic [OPW-1:0] opnd_b,
  input logic           ld_hi_en,
  input logic           ld_lo_en,
  input logic [OPW-1:0] ld_data,
  input logic [OPW-1:0] acc_hi,
  input logic [OPW-1:0] acc_lo,
  input logic [OPW-1:0] rd_value,
  input logic           rd_valid
);
  localparam int ACCW = 2 * OPW;

  logic [ACCW-1:0] sum;
  logic [ACCW-1:0] full_prod;
  logic [ACCW-1:0] sum_sh;
  logic            is_add, is_sub, is_drain, quiet;

  assign sum       = {acc_hi, acc_lo};
  assign full_prod = {{OPW{opnd_a[OPW-1]}}, opnd_a} * {{OPW{opnd_b[OPW-1]}}, opnd_b};
  assign sum_sh    = ACCW'($signed(sum) >>> SHIFT);
  assign is_add    = op_valid && op_code == 2'b01;
  assign is_sub    = op_valid && op_code == 2'b10;
  assign is_drain  = op_valid && op_code == 2'b11;
  assign quiet     = (!op_valid && !ld_hi_en && !ld_lo_en) || (op_valid && op_code == 2'b00);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (sum == '0 && rd_value == '0 && !rd_valid));

  // R2
  add_chk: assert property (@(posedge clk) disable iff (rst)
    is_add |=> sum == $past(sum) + $past(full_prod));

  // R3
  sub_chk: assert property (@(posedge clk) disable iff (rst)
    is_sub |=> sum == $past(sum) - $past(full_prod));

  // R5
  drain_chk: assert property (@(posedge clk) disable iff (rst)
    is_drain |=> (sum == '0 && rd_value == $past(sum_sh[OPW-1:0])));

  // R6
  pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !is_drain |=> !rd_valid);

  // R8
  quiet_chk: assert property (@(posedge clk) disable iff (rst)
    quiet |=> ($stable(sum) && $stable(rd_value)));

  // R9
  load_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (!op_valid && ld_hi_en) |=> acc_hi == $past(ld_data));

  // R9
  load_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (!op_valid && ld_lo_en && !ld_hi_en) |=> (acc_lo == $past(ld_data) && $stable(acc_hi)));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !is_drain |=> $stable(rd_value));
endmodule

bind macc_unit macc_unit_chk #(.OPW(OPW), .SHIFT(SHIFT)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .op_valid (op_valid),
  .op_code  (op_code),
  .opnd_a   (opnd_a),
  .opnd_b   (opnd_b),
  .ld_hi_en (ld_hi_en),
  .ld_lo_en (ld_lo_en),
  .ld_data  (ld_data),
  .acc_hi   (acc_hi),
  .acc_lo   (acc_lo),
  .rd_value (rd_value),
  .rd_valid (rd_valid)
);

// File: tb/tb_macc_unit.sv
`timescale 1ns/1ps
module tb_macc_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [1:0]  op_code = 2'b00;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic        ld_hi_en = 1'b0, ld_lo_en = 1'b0;
  logic [31:0] ld_data = '0;
  logic [31:0] acc_hi, acc_lo, rd_value;
  logic        rd_valid;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [63:0] m_acc;
  logic [31:0] m_rd;

  always #2.5 clk = ~clk;

  macc_unit dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .ld_hi_en(ld_hi_en), .ld_lo_en(ld_lo_en),
    .ld_data(ld_data), .acc_hi(acc_hi), .acc_lo(acc_lo),
    .rd_value(rd_value), .rd_valid(rd_valid)
  );

  function automatic logic [63:0] prod64(logic [31:0] a, logic [31:0] b);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    return 64'(sa * sb);
  endfunction

  function automatic logic [31:0] window(logic [63:0] v);
    longint s = longint'(v);
    return 32'(s >>> 28);
  endfunction

  task automatic cmp(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at a falling edge; return at the next falling edge, after the rising edge.
  task automatic apply(bit v, logic [1:0] op, logic [31:0] a, logic [31:0] b,
                       bit lh, bit ll, logic [31:0] d);
    op_valid = v; op_code = op; opnd_a = a; opnd_b = b;
    ld_hi_en = lh; ld_lo_en = ll; ld_data = d;
    @(negedge clk);
    op_valid = 0; op_code = 2'b00; ld_hi_en = 0; ld_lo_en = 0;
  endtask

  task automatic drain_and_check(string tag);
    m_rd = window(m_acc);
    apply(1, 2'b11, '0, '0, 0, 0, '0);
    m_acc = '0;
    cmp({"R5 value ", tag}, {32'h0, rd_value}, {32'h0, m_rd});
    cmp({"R5 clear ", tag}, {acc_hi, acc_lo}, 64'h0);
    cmp({"R6 pulse ", tag}, {63'h0, rd_valid}, 64'h1);
    apply(0, 2'b00, '0, '0, 0, 0, '0);
    cmp({"R6 low ", tag}, {63'h0, rd_valid}, 64'h0);
    cmp({"R11 hold ", tag}, {32'h0, rd_value}, {32'h0, m_rd});
  endtask

  logic [31:0] vals [8];

  initial begin
    vals = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
             32'h8000_0000, 32'h1234_5678, 32'hFEDC_BA98, 32'h0001_0000};
    m_acc = '0;
    m_rd  = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    cmp("R1 acc", {acc_hi, acc_lo}, 64'h0);
    cmp("R1 rd_value", {32'h0, rd_value}, 64'h0);
    cmp("R1 rd_valid", {63'h0, rd_valid}, 64'h0);

    // R2 / R3 sweep over all ordered edge pairs
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        apply(1, 2'b01, vals[i], vals[j], 0, 0, '0);
        m_acc = m_acc + prod64(vals[i], vals[j]);
        cmp("R2 add", {acc_hi, acc_lo}, m_acc);
        apply(1, 2'b10, vals[j], vals[(i + 3) % 8], 0, 0, '0);
        m_acc = m_acc - prod64(vals[j], vals[(i + 3) % 8]);
        cmp("R3 sub", {acc_hi, acc_lo}, m_acc);
      end
      // R7 drain immediately after an add, which must be included
      apply(1, 2'b01, vals[i], 32'h7654_3210, 0, 0, '0);
      m_acc = m_acc + prod64(vals[i], 32'h7654_3210);
      drain_and_check("R7 after add");
    end

    // R4 wrap at the positive limit
    apply(0, 2'b00, '0, '0, 1, 1, 32'hFFFF_FFFF);
    apply(0, 2'b00, '0, '0, 1, 0, 32'h7FFF_FFFF);
    m_acc = 64'h7FFF_FFFF_FFFF_FFFF;
    cmp("R9 hi load", {acc_hi, acc_lo}, m_acc);
    apply(1, 2'b01, 32'h1, 32'h1, 0, 0, '0);
    m_acc = 64'h8000_0000_0000_0000;
    cmp("R4 wrap", {acc_hi, acc_lo}, m_acc);

    // R5 negative sum drains with sign: -2^32 >>> 28 = -16
    apply(0, 2'b00, '0, '0, 1, 1, 32'h0);
    cmp("R9 dual load", {acc_hi, acc_lo}, 64'h0);
    apply(0, 2'b00, '0, '0, 1, 0, 32'hFFFF_FFFF);
    m_acc = 64'hFFFF_FFFF_0000_0000;
    cmp("R9 hi only", {acc_hi, acc_lo}, m_acc);
    drain_and_check("negative");
    cmp("R5 sign window", {32'h0, rd_value}, 64'hFFFF_FFF0);

    // R9 low-only load leaves upper half
    apply(0, 2'b00, '0, '0, 1, 0, 32'hA5A5_0001);
    apply(0, 2'b00, '0, '0, 0, 1, 32'h0BAD_F00D);
    m_acc = 64'hA5A5_0001_0BAD_F00D;
    cmp("R9 lo only", {acc_hi, acc_lo}, m_acc);

    // R8 strobe low with an add code, and idle code with strobe high
    apply(0, 2'b01, 32'h5, 32'h7, 0, 0, '0);
    cmp("R8 strobe low", {acc_hi, acc_lo}, m_acc);
    apply(1, 2'b00, 32'h5, 32'h7, 0, 0, '0);
    cmp("R8 idle code", {acc_hi, acc_lo}, m_acc);
    cmp("R8 rd_valid idle", {63'h0, rd_valid}, 64'h0);

    // R10 load colliding with an operation is dropped
    apply(1, 2'b01, 32'h3, 32'hFFFF_FFFE, 1, 1, 32'h1111_2222);
    m_acc = m_acc + prod64(32'h3, 32'hFFFF_FFFE);
    cmp("R10 add wins", {acc_hi, acc_lo}, m_acc);
    apply(1, 2'b10, 32'h8000_0000, 32'h8000_0000, 1, 0, 32'h3333_4444);
    m_acc = m_acc - prod64(32'h8000_0000, 32'h8000_0000);
    cmp("R10 sub wins", {acc_hi, acc_lo}, m_acc);
    m_rd = window(m_acc);
    apply(1, 2'b11, '0, '0, 0, 1, 32'h5555_6666);
    cmp("R10 drain wins", {acc_hi, acc_lo}, 64'h0);
    cmp("R5 drain value", {32'h0, rd_value}, {32'h0, m_rd});
    m_acc = '0;

    // R1 reset in mid-run
    apply(1, 2'b01, 32'h9, 32'h9, 0, 0, '0);
    rst = 1;
    @(negedge clk);
    rst = 0;
    cmp("R1 mid reset", {acc_hi, acc_lo}, 64'h0);
    cmp("R1 mid reset rd", {32'h0, rd_value}, 64'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule